// File: doc/BRIEF.md
# Second-Operand Shifter Unit

This unit builds the second operand of a data-processing datapath, together with the carry bit that the shift produces. It is the stage between register read and the ALU. The operand then goes straight into the ALU, so one operation can shift a value and compute with it in the same instruction.

Four operand forms are selected by `sel_form`:

- **Immediate.** An 8-bit constant is rotated right by an even amount.
- **Plain register.** A register value passes through unchanged.
- **Register shifted by an immediate amount.** The amount comes from a 5-bit field.
- **Register shifted by a register amount.** The amount comes from the low byte of a second register.

Five shift kinds are selected by `sel_kind`: logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry.

The result and the carry are registered. Both appear on the clock edge after the inputs are presented, and a synchronous active-high reset clears them.

Top module: `shifter_operand_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `opnd_out` and `carry_out` become 0 at that edge.
- R2: Outputs are registered: the result for inputs present at one rising edge appears after that edge. With form code 0 (immediate), `opnd_out` is `imm_const` zero-extended to 32 bits and rotated right by twice `imm_rot`, giving even rotations 0 to 30.
- R3: In form 0, `carry_out` equals `carry_in` when `imm_rot` is 0. Otherwise it equals bit 31 of the rotated result.
- R4: With form code 1 (plain register), `opnd_out` equals `rm_val` and `carry_out` equals `carry_in`.
- R5: Form code 2 takes the shift amount from `sh_imm` (0 to 31). Form code 3 takes it from `rs_byte` (0 to 255). The amount input that the selected form does not use has no effect on either output.
- R6: For kind codes 0, 1, 2 and 3, an effective amount of 0 leaves the value unchanged and passes `carry_in` to `carry_out`.
- R7: In form 2, an `sh_imm` of 0 with kind 1 (logical right) or kind 2 (arithmetic right) is taken as a shift by 32.
- R8: Kind 0 (logical left) and kind 1 (logical right) with an amount n from 1 to 32 fill with zeros. The carry is the last bit shifted out: bit 32-n for left, bit n-1 for right. For an amount above 32, the result and the carry are both 0.
- R9: Kind 2 (arithmetic right) fills with the sign bit. For an amount from 1 to 31 the carry is bit n-1. For 32 or more, every result bit and the carry equal bit 31 of `rm_val`.
- R10: Kind 3 (rotate right) rotates by the amount modulo 32. For a nonzero amount the carry is bit 31 of the result. A nonzero multiple of 32 leaves the value unchanged.
- R11: Kind 4 (rotate through carry) in forms 2 and 3 gives `{carry_in, rm_val[31:1]}` with carry `rm_val[0]`, whatever the amount fields hold.
- R12: Kind codes 5, 6 and 7 behave as logical left (kind 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_form | input | 2 | Operand form: 0 immediate, 1 register, 2 shift by immediate, 3 shift by register |
| sel_kind | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry |
| imm_const | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation is twice this value) |
| sh_imm | input | 5 | Immediate shift amount |
| rm_val | input | 32 | Value to be shifted |
| rs_byte | input | 8 | Low byte of the shift-amount register |
| carry_in | input | 1 | Incoming carry flag |
| opnd_out | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The bench sweeps every combination of immediate constant and rotate field. It also runs every shift kind over register amounts 0 to 40 and at the large amounts 63, 64, 65, 128, 200 and 255. Each run is repeated with sign-heavy, all-ones, all-zero and random values, and with both carry inputs.

These sweeps target specific mistakes:

- **Zero-rotate immediate.** A design that took the carry from bit 31 here would lose the incoming carry.
- **Immediate right shift of 0.** A design that read it literally would return the value unchanged instead of clearing it or filling it with the sign.
- **Amount of exactly 32 or a multiple of 32.** Off-by-one carry selection shows up here as a wrong carry bit.
- **Rotate modulo 32.** A design that treated 32 like 0 would keep `carry_in` where bit 31 belongs.

Unused amount fields are filled with random values throughout, so a design that read the wrong amount source shows up as mismatches.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;

  typedef enum logic [1:0] {
    FORM_IMM   = 2'd0,
    FORM_REG   = 2'd1,
    FORM_SHIMM = 2'd2,
    FORM_SHREG = 2'd3
  } opnd_form_e;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

endpackage

// File: rtl/opnd_imm_rotator.sv
module opnd_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_const,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              carry_in,
  output logic [DATA_W-1:0] rot_val,
  output logic              rot_carry
);
  localparam int RK_W = $clog2(DATA_W);
  localparam logic [RK_W:0] FULL = (RK_W+1)'(DATA_W);

  logic [DATA_W-1:0] zext;
  logic [RK_W:0]     rot_amt;
  logic [RK_W:0]     rot_inv;

  always_comb begin
    zext      = {{(DATA_W-IMM_W){1'b0}}, imm_const};
    // rotation is always even: field value doubled
    rot_amt   = (RK_W+1)'({imm_rot, 1'b0});
    rot_inv   = FULL - rot_amt;
    rot_val   = (zext >> rot_amt) | (zext << rot_inv);
    rot_carry = (imm_rot == '0) ? carry_in : rot_val[DATA_W-1];
  end

endmodule

// File: rtl/opnd_amount_sel.sv
module opnd_amount_sel
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIMM_W = 5,
  parameter int SHREG_W = 8,
  parameter int AMT_W   = SHREG_W + 1
) (
  input  logic [1:0]         sel_form,
  input  logic [2:0]         sel_kind,
  input  logic [SHIMM_W-1:0] sh_imm,
  input  logic [SHREG_W-1:0] rs_byte,
  output logic [AMT_W-1:0]   amt
);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);

  always_comb begin
    amt = '0;
    if (sel_form == FORM_SHREG) begin
      amt = AMT_W'(rs_byte);
    end else if (sel_form == FORM_SHIMM) begin
      // an immediate right shift of zero encodes a full-width shift
      if (sh_imm == '0 && (sel_kind == SK_LSR || sel_kind == SK_ASR))
        amt = AMT_FULL;
      else
        amt = AMT_W'(sh_imm);
    end
  end

endmodule

// File: rtl/opnd_reg_shifter.sv
module opnd_reg_shifter
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 9
) (
  input  logic [DATA_W-1:0] val,
  input  logic [AMT_W-1:0]  amt,
  input  logic [2:0]        kind,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              res_carry
);
  localparam int RK_W = $clog2(DATA_W);
  localparam logic [RK_W:0] FULL = (RK_W+1)'(DATA_W);

  // one extra bit on the exit side catches the last bit shifted out
  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_w;
  logic [RK_W-1:0]        rk;
  logic [RK_W:0]          rk_inv;
  logic [DATA_W-1:0]      ror_v;

  always_comb begin
    lsl_w  = {1'b0, val} << amt;
    lsr_w  = {val, 1'b0} >> amt;
    asr_w  = $signed({val, 1'b0}) >>> amt;
    rk     = amt[RK_W-1:0];
    rk_inv = FULL - {1'b0, rk};
    ror_v  = (val >> rk) | (val << rk_inv);

    if (amt == '0 && kind != SK_RRX) begin
      res       = val;
      res_carry = carry_in;
    end else begin
      case (kind)
        SK_LSR: begin
          res       = lsr_w[DATA_W:1];
          res_carry = lsr_w[0];
        end
        SK_ASR: begin
          res       = asr_w[DATA_W:1];
          res_carry = asr_w[0];
        end
        SK_ROR: begin
          res       = ror_v;
          res_carry = ror_v[DATA_W-1];
        end
        SK_RRX: begin
          res       = {carry_in, val[DATA_W-1:1]};
          res_carry = val[0];
        end
        default: begin
          res       = lsl_w[DATA_W-1:0];
          res_carry = lsl_w[DATA_W];
        end
      endcase
    end
  end

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int SHIMM_W = 5,
  parameter int SHREG_W = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         sel_form,
  input  logic [2:0]         sel_kind,
  input  logic [IMM_W-1:0]   imm_const,
  input  logic [ROT_W-1:0]   imm_rot,
  input  logic [SHIMM_W-1:0] sh_imm,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [SHREG_W-1:0] rs_byte,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  opnd_out,
  output logic               carry_out
);
  localparam int AMT_W = SHREG_W + 1;

  logic [DATA_W-1:0] imm_v;
  logic              imm_c;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] sh_v;
  logic              sh_c;
  logic [DATA_W-1:0] opnd_d;
  logic              carry_d;

  opnd_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_const (imm_const),
    .imm_rot   (imm_rot),
    .carry_in  (carry_in),
    .rot_val   (imm_v),
    .rot_carry (imm_c)
  );

  opnd_amount_sel #(.DATA_W(DATA_W), .SHIMM_W(SHIMM_W), .SHREG_W(SHREG_W),
                    .AMT_W(AMT_W)) u_amt (
    .sel_form (sel_form),
    .sel_kind (sel_kind),
    .sh_imm   (sh_imm),
    .rs_byte  (rs_byte),
    .amt      (amt)
  );

  opnd_reg_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .val       (rm_val),
    .amt       (amt),
    .kind      (sel_kind),
    .carry_in  (carry_in),
    .res       (sh_v),
    .res_carry (sh_c)
  );

  always_comb begin
    case (sel_form)
      FORM_IMM: begin
        opnd_d  = imm_v;
        carry_d = imm_c;
      end
      FORM_REG: begin
        opnd_d  = rm_val;
        carry_d = carry_in;
      end
      default: begin
        opnd_d  = sh_v;
        carry_d = sh_c;
      end
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          opnd_out  <= '0;
          carry_out <= 1'b0;
        end else begin
          opnd_out  <= opnd_d;
          carry_out <= carry_d;
        end
      end

      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (opnd_out == '0 && !carry_out)); // R1

      AST_IMM_ROT0: assert property (@(posedge clk) disable iff (rst)
        (sel_form == FORM_IMM && imm_rot == '0)
        |=> (opnd_out == DATA_W'($past(imm_const)) && carry_out == $past(carry_in))); // R3

      AST_IMM_CARRY_TOP: assert property (@(posedge clk) disable iff (rst)
        (sel_form == FORM_IMM && imm_rot != '0)
        |=> (carry_out == opnd_out[DATA_W-1])); // R3

      AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (sel_form == FORM_REG)
        |=> (opnd_out == $past(rm_val) && carry_out == $past(carry_in))); // R4

      AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (rst)
        (sel_form == FORM_SHREG && rs_byte == '0 && sel_kind != SK_RRX)
        |=> (opnd_out == $past(rm_val) && carry_out == $past(carry_in))); // R6

      AST_LOGIC_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (sel_form == FORM_SHREG && rs_byte > SHREG_W'(DATA_W)
         && (sel_kind == SK_LSL || sel_kind == SK_LSR))
        |=> (opnd_out == '0 && !carry_out)); // R8

      AST_RRX_FILL: assert property (@(posedge clk) disable iff (rst)
        (sel_form[1] && sel_kind == SK_RRX)
        |=> (opnd_out[DATA_W-1] == $past(carry_in) && carry_out == $past(rm_val[0]))); // R11
    end else begin : g_comb
      assign opnd_out  = opnd_d;
      assign carry_out = carry_d;
    end
  endgenerate

endmodule

// File: tb/tb_shifter_operand_unit.sv
`timescale 1ns/1ps
module tb_shifter_operand_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  sel_form;
  logic [2:0]  sel_kind;
  logic [7:0]  imm_const;
  logic [3:0]  imm_rot;
  logic [4:0]  sh_imm;
  logic [31:0] rm_val;
  logic [7:0]  rs_byte;
  logic        carry_in;
  logic [31:0] opnd_out;
  logic        carry_out;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  shifter_operand_unit dut (
    .clk(clk), .rst(rst), .sel_form(sel_form), .sel_kind(sel_kind),
    .imm_const(imm_const), .imm_rot(imm_rot), .sh_imm(sh_imm),
    .rm_val(rm_val), .rs_byte(rs_byte), .carry_in(carry_in),
    .opnd_out(opnd_out), .carry_out(carry_out)
  );

  // bit-serial reference, one place per step
  function automatic logic [32:0] ref_model(input logic [1:0] f, input logic [2:0] k,
      input logic [7:0] imm, input logic [3:0] rot, input logic [4:0] shi,
      input logic [7:0] rsb, input logic [31:0] rm, input logic ci);
    logic [31:0] v = rm;
    logic        c = ci;
    int          n;
    if (f == 2'd0) begin
      v = {24'b0, imm};
      for (int i = 0; i < 2 * int'(rot); i++) v = {v[0], v[31:1]};
      c = (rot == 4'd0) ? ci : v[31];
    end else if (f != 2'd1) begin
      n = (f == 2'd2) ? int'(shi) : int'(rsb);
      if (f == 2'd2 && shi == 5'd0 && (k == 3'd1 || k == 3'd2)) n = 32;
      if (k == 3'd4) begin
        c = v[0];
        v = {ci, v[31:1]};
      end else begin
        for (int i = 0; i < n; i++) begin
          case (k)
            3'd1:    begin c = v[0];  v = {1'b0, v[31:1]};  end
            3'd2:    begin c = v[0];  v = {v[31], v[31:1]}; end
            3'd3:    begin c = v[0];  v = {v[0], v[31:1]};  end
            default: begin c = v[31]; v = {v[30:0], 1'b0};  end
          endcase
        end
      end
    end
    return {c, v};
  endfunction

  function automatic string pick_tag(input logic [1:0] f, input logic [2:0] k,
      input logic [3:0] rot, input logic [4:0] shi, input logic [7:0] rsb);
    int n;
    if (f == 2'd0) return (rot == 4'd0) ? "R3" : "R2";
    if (f == 2'd1) return "R4";
    if (k == 3'd4) return "R11";
    if (k > 3'd4)  return "R12";
    n = (f == 2'd2) ? int'(shi) : int'(rsb);
    if (f == 2'd2 && n == 0 && (k == 3'd1 || k == 3'd2)) return "R7";
    if (n == 0)    return "R6";
    if (k == 3'd3) return "R10";
    if (k == 3'd2) return "R9";
    return "R8";
  endfunction

  task automatic apply(input logic [1:0] f, input logic [2:0] k, input logic [7:0] imm,
      input logic [3:0] rot, input logic [4:0] shi, input logic [7:0] rsb,
      input logic [31:0] rm, input logic ci, input string tag);
    logic [32:0] exp;
    string       t;
    @(negedge clk);
    sel_form = f; sel_kind = k; imm_const = imm; imm_rot = rot;
    sh_imm = shi; rs_byte = rsb; rm_val = rm; carry_in = ci;
    exp = ref_model(f, k, imm, rot, shi, rsb, rm, ci);
    t = (tag == "") ? pick_tag(f, k, rot, shi, rsb) : tag;
    @(negedge clk);
    total++;
    if ({carry_out, opnd_out} !== exp) begin
      bad++;
      $display("FAIL %s form=%0d kind=%0d: actual val=%h c=%b expected val=%h c=%b",
               t, f, k, opnd_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    int          amts [47];
    int          na;
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0000;
    pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5C3_0F96; pats[5] = $urandom;
    na = 0;
    for (int a = 0; a <= 40; a++) begin amts[na] = a; na++; end
    amts[41] = 63; amts[42] = 64; amts[43] = 65;
    amts[44] = 128; amts[45] = 200; amts[46] = 255;

    // R1: reset with live inputs
    rst = 1'b1; sel_form = 2'd1; sel_kind = 3'd0; imm_const = 8'hFF; imm_rot = 4'd3;
    sh_imm = 5'd7; rs_byte = 8'd9; rm_val = 32'hDEAD_BEEF; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (opnd_out !== 32'h0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual val=%h c=%b expected val=0 c=0", opnd_out, carry_out);
    end
    rst = 1'b0;

    // R2 R3: every immediate constant and rotate field
    for (int r = 0; r < 16; r++)
      for (int i = 0; i < 256; i++)
        apply(2'd0, 3'($urandom), 8'(i), 4'(r), 5'($urandom), 8'($urandom),
              $urandom, 1'($urandom), "");

    // R4: plain register
    for (int p = 0; p < 6; p++)
      for (int ci = 0; ci < 2; ci++)
        apply(2'd1, 3'($urandom), 8'($urandom), 4'($urandom), 5'($urandom),
              8'($urandom), pats[p], 1'(ci), "R4");

    // R5-R12: all kinds, both amount sources, unused source randomised
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 6; p++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a < 32; a++)
            apply(2'd2, 3'(k), 8'($urandom), 4'($urandom), 5'(a), 8'($urandom),
                  pats[p], 1'(ci), "");
          for (int j = 0; j < 47; j++)
            apply(2'd3, 3'(k), 8'($urandom), 4'($urandom), 5'($urandom), 8'(amts[j]),
                  pats[p], 1'(ci), "");
        end

    // R5: same amount through each source with the other source varied
    for (int j = 0; j < 20; j++) begin
      apply(2'd2, 3'd3, 8'h0, 4'h0, 5'd9, 8'(j * 13), 32'h1234_5678, 1'b0, "R5");
      apply(2'd3, 3'd3, 8'h0, 4'h0, 5'(j), 8'd9, 32'h1234_5678, 1'b0, "R5");
    end

    // R1: reset mid-run after a nonzero result
    apply(2'd1, 3'd0, 8'h0, 4'h0, 5'h0, 8'h0, 32'hFFFF_0000, 1'b1, "R4");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    total++;
    if (opnd_out !== 32'h0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 mid reset: actual val=%h c=%b expected val=0 c=0", opnd_out, carry_out);
    end
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule